// File: doc/BRIEF.md
# Transmit BIST Pattern Generator with Loop Status

This block produces the transmit-side self-test character stream. A 9-bit linear feedback shift register in XNOR form steps once per character clock while the active-low test enable is held low. Its state is presented directly as the outgoing 9-bit character. The register runs through 511 of its 512 possible states. Each time it presents the all-zero state, one pass through the test sequence has finished, and the block raises a loop-complete status flag.

The flag behaves in one of two ways, chosen by a bypass-mode select. In FIFO mode the flag is a single sticky latch: it holds a completion until the host addresses the block and reads it. Several completions between two reads therefore merge into one indication. In bypass mode nothing is stored. The flag shows the live loop event for one character period out of every 511, and a host that does not look in that cycle misses it.

Chip select is sampled on every clock. The output driver for the flag is modelled as an enable that is high in the cycle after chip select was sampled low. While the test enable is high, the generator is parked at its seed value and the flag is held low.

Top module: `bist_tx_pattern_gen`

## Requirements
- R1: While `bistEnN` is high, and after reset, `charOut` equals the parameter SEED (default 9'h0A5, which must not be 9'h1FF) and `loopFlag` is 0.
- R2: While `bistEnN` is low, each clock loads `charOut` with {s[7:0], ~(s[8] ^ s[4])}, where s is the current value. The value 9'h1FF never appears. The sequence repeats with period 511 and passes through every other 9-bit value once per period.
- R3: A loop completion is the cycle in which `charOut` is 9'h000 while `bistEnN` is low. The first completion comes after as many clocks as the seed needs to reach 9'h000, which can be far fewer than 511.
- R4: After the first completion, further completions occur exactly 511 clocks apart for as long as `bistEnN` stays low.
- R5: In FIFO mode (`fifoBypass` = 0), `loopFlag` rises on the clock that follows a completion. It stays high through any number of clocks, and through any number of further completions, until it is read.
- R6: A read is a cycle in FIFO mode where `flagOe` is 1. A read clears `loopFlag` on the next clock, unless a completion occurs in the same cycle as the read, in which case `loopFlag` is 1 on the next clock.
- R7: In bypass mode (`fifoBypass` = 1), `loopFlag` is 1 only in the single cycle after each completion. It keeps no memory of completions and ignores `csN`.
- R8: `flagOe` is 1 in the cycle after a clock edge at which `csN` was low, and 0 in the cycle after an edge at which `csN` was high.
- R9: A clock edge at which `bistEnN` is high clears `loopFlag` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bistEnN | input | 1 | Active-low transmit test enable |
| fifoBypass | input | 1 | 1 selects the dynamic flag (bypass mode), 0 selects the sticky flag (FIFO mode) |
| csN | input | 1 | Active-low chip select, sampled on each clock |
| charOut | output | 9 | Generator state, used as the outgoing test character |
| loopFlag | output | 1 | Loop-complete status |
| flagOe | output | 1 | Output-driver enable for the status flag |

## Verification
The hardest case to reach from the ports is a read that falls in exactly the same cycle as a loop completion. For that case the flag must survive the read instead of being cleared. The bench runs its own arithmetic model of the shift register alongside the design. It drops chip select on the edge whose computed successor state is 9'h000, so the sampled select and the zero state coincide. The bench then checks that the flag is still set one clock later. Completion spacing and the full 511-state coverage are also checked. This is done by recording every state the design presents between two consecutive zero states.

// File: rtl/bist_tx_pkg.sv
`timescale 1ns/1ps
package bist_tx_pkg;
  // Strobes from the flag control to the generator datapath
  typedef struct packed {
    logic load;     // park the generator at its seed
    logic advance;  // step the generator by one character
  } genStrobe_t;
endpackage

// File: rtl/bist_tx_lfsr_dp.sv
`timescale 1ns/1ps
module bist_tx_lfsr_dp
  import bist_tx_pkg::*;
#(
  parameter int WIDTH  = 9,
  parameter int TAP_HI = 9,
  parameter int TAP_LO = 5,
  parameter logic [WIDTH-1:0] SEED = 9'h0A5
) (
  input  logic             clk,
  input  logic             rstN,
  input  genStrobe_t       strobe,
  output logic [WIDTH-1:0] charOut,
  output logic             zeroHit
);
  localparam logic [WIDTH-1:0] LOCK_STATE = {WIDTH{1'b1}};
  localparam int HI_IDX = TAP_HI - 1;
  localparam int LO_IDX = TAP_LO - 1;

  logic [WIDTH-1:0] lfsrQ;
  logic [WIDTH-1:0] lfsrNext;
  logic             feedback;

  // XNOR feedback keeps all-ones as the only excluded state
  assign feedback = ~(lfsrQ[HI_IDX] ^ lfsrQ[LO_IDX]);

  always_comb begin
    lfsrNext = lfsrQ;
    if (strobe.load)         lfsrNext = SEED;
    else if (strobe.advance) lfsrNext = {lfsrQ[WIDTH-2:0], feedback};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= SEED;
    else       lfsrQ <= lfsrNext;
  end

  assign charOut = lfsrQ;
  assign zeroHit = (lfsrQ == '0);

  // R2: lock-up state is never entered
  assert_no_lockup_R2: assert property (@(posedge clk) disable iff (!rstN)
    charOut != LOCK_STATE);

  // R2: advancing shifts the register up by one position
  assert_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !strobe.load |=> charOut[WIDTH-1:1] == $past(charOut[WIDTH-2:0]));

  // R1: a load strobe parks the generator at the seed
  assert_park_seed_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> charOut == SEED);
endmodule

// File: rtl/bist_tx_flag_ctrl.sv
`timescale 1ns/1ps
module bist_tx_flag_ctrl
  import bist_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bistEnN,
  input  logic       fifoBypass,
  input  logic       csN,
  input  logic       zeroHit,
  output genStrobe_t strobe,
  output logic       loopFlag,
  output logic       flagOe
);
  logic bistActive;
  logic loopHit;
  logic csSampledQ;
  logic stickyQ;
  logic stickyNext;
  logic dynQ;

  assign bistActive = !bistEnN;
  assign loopHit    = bistActive && zeroHit;

  always_comb begin
    strobe         = '0;
    strobe.load    = !bistActive;
    strobe.advance = bistActive;
  end

  // Sticky latch: a new completion wins over a clearing read
  always_comb begin
    if (!bistActive || fifoBypass) stickyNext = 1'b0;
    else if (loopHit)              stickyNext = 1'b1;
    else if (csSampledQ)           stickyNext = 1'b0;
    else                           stickyNext = stickyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSampledQ <= 1'b0;
      stickyQ    <= 1'b0;
      dynQ       <= 1'b0;
    end else begin
      csSampledQ <= !csN;
      stickyQ    <= stickyNext;
      dynQ       <= loopHit && fifoBypass;
    end
  end

  assign flagOe   = csSampledQ;
  assign loopFlag = fifoBypass ? dynQ : stickyQ;

  // R3: a completion in FIFO mode raises the flag next clock
  assert_loop_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    !bistEnN && zeroHit && !fifoBypass |=> loopFlag);

  // R5: an unread flag in FIFO mode is held
  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !fifoBypass && !bistEnN && loopFlag && !flagOe |=> fifoBypass || loopFlag);

  // R6: a read without a coincident completion clears the flag
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    !fifoBypass && !bistEnN && flagOe && !zeroHit |=> !loopFlag);

  // R7: in bypass mode the flag lasts one cycle
  assert_bypass_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoBypass && loopFlag |=> !loopFlag);

  // R8: driver enable follows the sampled chip select
  assert_oe_on_R8: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> flagOe);
  assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !flagOe);

  // R9: leaving test mode clears the flag
  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    bistEnN |=> !loopFlag);
endmodule

// File: rtl/bist_tx_pattern_gen.sv
`timescale 1ns/1ps
module bist_tx_pattern_gen
  import bist_tx_pkg::*;
#(
  parameter int WIDTH  = 9,
  parameter int TAP_HI = 9,
  parameter int TAP_LO = 5,
  parameter logic [WIDTH-1:0] SEED = 9'h0A5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bistEnN,
  input  logic             fifoBypass,
  input  logic             csN,
  output logic [WIDTH-1:0] charOut,
  output logic             loopFlag,
  output logic             flagOe
);
  genStrobe_t genStrobe;
  logic       zeroHit;

  bist_tx_flag_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bistEnN    (bistEnN),
    .fifoBypass (fifoBypass),
    .csN        (csN),
    .zeroHit    (zeroHit),
    .strobe     (genStrobe),
    .loopFlag   (loopFlag),
    .flagOe     (flagOe)
  );

  bist_tx_lfsr_dp #(
    .WIDTH  (WIDTH),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO),
    .SEED   (SEED)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (genStrobe),
    .charOut (charOut),
    .zeroHit (zeroHit)
  );
endmodule

// File: tb/bist_tx_pattern_gen_tb.sv
`timescale 1ns/1ps
module bist_tx_pattern_gen_tb;
  localparam logic [8:0] SEED = 9'h0A5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bistEnN = 1'b1;
  logic       fifoBypass = 1'b0;
  logic       csN = 1'b1;
  logic [8:0] charOut;
  logic       loopFlag;
  logic       flagOe;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;
  bit done   = 1'b0;

  // model state
  logic [8:0] mState = SEED;
  logic       mSticky = 1'b0;
  logic       mDyn = 1'b0;
  logic       mCs = 1'b0;

  always #2 clk = ~clk;

  bist_tx_pattern_gen #(.SEED(SEED)) u_dut (
    .clk(clk), .rstN(rstN), .bistEnN(bistEnN), .fifoBypass(fifoBypass),
    .csN(csN), .charOut(charOut), .loopFlag(loopFlag), .flagOe(flagOe)
  );

  function automatic logic [8:0] stepOf(input logic [8:0] s);
    return {s[7:0], ~(s[8] ^ s[4])};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycle);
    end
  endtask

  task automatic tick();
    logic act, hit;
    logic [8:0] nState;
    logic nSticky, nDyn, nCs;
    act     = !bistEnN;
    hit     = act && (mState == 9'h000);
    nState  = act ? stepOf(mState) : SEED;
    nSticky = (!act || fifoBypass) ? 1'b0 : hit ? 1'b1 : mCs ? 1'b0 : mSticky;
    nDyn    = act && fifoBypass && hit;
    nCs     = !csN;
    @(posedge clk); #1;
    mState = nState; mSticky = nSticky; mDyn = nDyn; mCs = nCs;
    cycle++;
  endtask

  task automatic compareAll();
    logic expFlag;
    expFlag = fifoBypass ? mDyn : mSticky;
    chk(charOut == mState, "R2 character sequence", charOut, mState);
    chk(loopFlag == expFlag, fifoBypass ? "R7 bypass flag" : "R5/R6 sticky flag", loopFlag, expFlag);
    chk(flagOe == mCs, "R8 driver enable", flagOe, mCs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int firstPass;
    int zeroCycles[$];
    bit seen[512];
    int distinct;
    bit sawLock;
    int pulses;
    int expPulses;
    logic [8:0] s;

    // expected length of the first pass from the seed
    s = SEED; firstPass = 0;
    while (s != 9'h000) begin s = stepOf(s); firstPass++; end

    #5;
    chk(charOut == SEED, "R1 reset character", charOut, SEED);
    chk(loopFlag == 1'b0, "R1 reset flag", loopFlag, 0);
    chk(flagOe == 1'b0, "R8 reset enable", flagOe, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;

    // R1: parked while disabled
    for (int i = 0; i < 5; i++) begin tick(); compareAll(); end
    chk(charOut == SEED, "R1 parked at seed", charOut, SEED);

    // FIFO mode, no polling
    bistEnN = 1'b0;
    for (int i = 0; i < firstPass + 1100; i++) begin
      tick(); compareAll();
      if (charOut == 9'h000) zeroCycles.push_back(i + 1);
    end
    chk(zeroCycles.size() >= 3, "R4 completions seen", zeroCycles.size(), 3);
    if (zeroCycles.size() >= 3) begin
      chk(zeroCycles[0] == firstPass, "R3 first pass length", zeroCycles[0], firstPass);
      chk(zeroCycles[1] - zeroCycles[0] == 511, "R4 pass length", zeroCycles[1] - zeroCycles[0], 511);
      chk(zeroCycles[2] - zeroCycles[1] == 511, "R4 pass length", zeroCycles[2] - zeroCycles[1], 511);
    end
    chk(loopFlag == 1'b1, "R5 merged completions held", loopFlag, 1);

    // R2: full period coverage between two zero states
    while (charOut != 9'h000) begin tick(); compareAll(); end
    foreach (seen[k]) seen[k] = 1'b0;
    distinct = 0; sawLock = 1'b0;
    for (int i = 0; i < 511; i++) begin
      if (!seen[charOut]) distinct++;
      seen[charOut] = 1'b1;
      if (charOut == 9'h1FF) sawLock = 1'b1;
      tick(); compareAll();
    end
    chk(distinct == 511, "R2 distinct states", distinct, 511);
    chk(!sawLock, "R2 lock state absent", sawLock, 0);
    chk(charOut == 9'h000, "R2 period 511", charOut, 0);

    // R6: periodic reads
    for (int i = 0; i < 700; i++) begin
      csN = (i % 53 == 0) ? 1'b0 : 1'b1;
      tick(); compareAll();
    end
    csN = 1'b1;

    // R6 corner: read coinciding with a completion
    while (stepOf(mState) != 9'h000) begin tick(); compareAll(); end
    csN = 1'b0;
    tick(); compareAll();
    chk(charOut == 9'h000 && flagOe, "R6 read meets completion setup", {flagOe, charOut}, 10'h200);
    csN = 1'b1;
    tick(); compareAll();
    chk(loopFlag == 1'b1, "R6 completion beats read", loopFlag, 1);
    tick(); compareAll();
    chk(loopFlag == 1'b1, "R5 held after unread completion", loopFlag, 1);
    csN = 1'b0;
    tick(); compareAll();
    csN = 1'b1;
    tick(); compareAll();
    chk(loopFlag == 1'b0, "R6 plain read clears", loopFlag, 0);

    // R7: bypass mode, chip select toggling ignored by the flag
    fifoBypass = 1'b1;
    pulses = 0; expPulses = 0;
    for (int i = 0; i < 1200; i++) begin
      csN = i[2];
      if (!bistEnN && mState == 9'h000) expPulses++;
      tick(); compareAll();
      if (loopFlag) pulses++;
    end
    chk(pulses == expPulses && pulses >= 2, "R7 one pulse per pass", pulses, expPulses);

    // R9: leaving test mode clears the flag, generator parks (R1)
    fifoBypass = 1'b0;
    while (stepOf(mState) != 9'h000) begin tick(); compareAll(); end
    tick(); tick(); compareAll();
    chk(loopFlag == 1'b1, "R5 flag set before disable", loopFlag, 1);
    bistEnN = 1'b1;
    tick(); compareAll();
    chk(loopFlag == 1'b0, "R9 disable clears flag", loopFlag, 0);
    chk(charOut == SEED, "R1 disable parks at seed", charOut, SEED);

    // R3: re-enable restarts the short first pass
    bistEnN = 1'b0;
    for (int i = 0; i < firstPass; i++) begin tick(); compareAll(); end
    chk(charOut == 9'h000, "R3 first pass after re-enable", charOut, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule